// File: doc/BRIEF.md
# Trigger-Started Synchronous Timer Counter

An up-counter timer whose counting can be switched on by hardware instead of software. A slave-side controller watches one selected trigger source, which is either the rising edge of an external input pin or the rising edge of an internal trigger line driven by a neighbouring timer. In trigger mode that edge sets the count-enable bit and raises a sticky trigger flag. It never clears the counter. A master-side selector exports one internal event on a trigger output, so a second copy of the block can be started from the first one.

Chaining works as follows. The first timer takes its start from the pin and exports its enable. The second timer takes its start from its internal trigger input. The first timer also has its lockstep bit set, which holds back its own first increment by one kernel-clock cycle. That cycle equals the one cycle the second timer needs to see the exported edge, so both counters leave their start values on the same clock edge. Software sets a counter offset between the two by writing one counter value before the start. The prescaler is fixed at divide-by-one.

All configuration arrives through a single-cycle write port made of an enable, an address and data.

Top module: `stt_timer`

## Requirements
- R1: After reset the counter reads 0, the enable bit and the trigger flag read 0, `trg_out` reads 0, and the wrap limit is all ones.
- R2: With trigger-select code 5'b00100 and slave-mode code 3'b110 in the MODE register (address 1; slave mode in bits [2:0], trigger select in [7:3], master select in [10:8], lockstep in bit 11), a rising edge on `ext_in` sets the enable at the next clock edge. An input held high does not trigger again.
- R3: With trigger-select code 5'b00000 and slave-mode code 3'b110, a rising edge on `itr_in` sets the enable at the next clock edge.
- R4: A selected trigger edge in trigger mode sets the trigger flag. The flag stays set until a write to STAT (address 4) with bit 0 equal to 0. Writing 1 has no effect. If a trigger and a clearing write land in the same cycle, the flag ends up set.
- R5: A trigger that arrives while the counter already runs sets the flag and leaves the count sequence unchanged.
- R6: When the slave-mode code is not 3'b110, or the trigger-select code is neither of the two supported codes, trigger edges change neither the enable nor the flag.
- R7: While running, the counter advances by one on each clock and goes from the wrap limit (ARR, address 3) to 0.
- R8: Writing EVT (address 5) with bit 0 set forces the counter to 0 at the next edge. This holds whether the counter is running or stopped.
- R9: Writing CNT (address 2) loads the counter at the next edge and takes precedence over that cycle's increment.
- R10: Master-select code 3'b001 makes `trg_out` equal to the enable bit. Code 3'b000 gives a one-cycle pulse in the cycle after a forced reset of the counter. Code 3'b010 gives a one-cycle pulse in the cycle after a wrap.
- R11: With the lockstep bit set, the first increment comes two clock edges after the trigger edge instead of one.
- R12: A lockstep timer exporting its enable, driving a second timer through `itr_in`, produces counts on both timers that step on the same edges and keep any preloaded offset.
- R13: Writing CTRL (address 0) bit 0 sets or clears the enable. Once the enable is clear the counter holds. A trigger in the same cycle as a clearing write leaves the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External timer input used as a trigger source |
| itr_in | input | 1 | Internal trigger from another timer |
| trg_out | output | 1 | Exported trigger event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| cnt_o | output | CNT_W | Current counter value |
| cen_o | output | 1 | Count-enable bit |
| tif_o | output | 1 | Sticky trigger flag |

## Verification
Two collisions matter most: a trigger edge against a software write in the same cycle, and a forced reset or load against the counter's own increment or wrap. The bench lines up the rising input edge with a clearing write to the flag or to the enable on one negative edge. It then expects the flag or the enable to be set after the next clock. Loads and forced resets are issued while the counter runs, and the value after the edge must be the written one, not the incremented one. Randomized limits and preloads make wraps fall on arbitrary cycles, including in the chained pair.

// File: rtl/stt_pkg.sv
package stt_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_CNT  = 3'd2,
    A_ARR  = 3'd3,
    A_STAT = 3'd4,
    A_EVT  = 3'd5
  } reg_addr_e;

  localparam logic [2:0] SM_OFF    = 3'b000;
  localparam logic [2:0] SM_TRIG   = 3'b110;
  localparam logic [4:0] TS_ITR0   = 5'b00000;
  localparam logic [4:0] TS_ETI1   = 5'b00100;
  localparam logic [2:0] MM_RESET  = 3'b000;
  localparam logic [2:0] MM_ENABLE = 3'b001;
  localparam logic [2:0] MM_UPDATE = 3'b010;

  localparam int MODE_W = 12;

  typedef struct packed {
    logic       msm;
    logic [2:0] msel;
    logic [4:0] tsel;
    logic [2:0] smode;
  } mode_t;

  function automatic logic pick_trigger(input logic [4:0] tsel,
                                        input logic ext_rise,
                                        input logic itr_rise);
    case (tsel)
      TS_ETI1: return ext_rise;
      TS_ITR0: return itr_rise;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stt_trig_sel.sv
module stt_trig_sel
  import stt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_in,
  input  logic       itr_in,
  input  logic [4:0] tsel,
  output logic       trig_evt
);

  logic ext_q, itr_q;
  logic ext_rise, itr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      itr_q <= 1'b0;
    end else begin
      ext_q <= ext_in;
      itr_q <= itr_in;
    end
  end

  assign ext_rise = ext_in & ~ext_q;
  assign itr_rise = itr_in & ~itr_q;
  assign trig_evt = pick_trigger(tsel, ext_rise, itr_rise);

  AST_LEVEL_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == TS_ETI1 && ext_in && $past(ext_in)) |-> !trig_evt); // R2

endmodule

// File: rtl/stt_slave_ctrl.sv
module stt_slave_ctrl
  import stt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_evt,
  input  logic [2:0] smode,
  input  logic       msm,
  input  logic       cen_we,
  input  logic       cen_wval,
  input  logic       tif_we,
  input  logic       tif_wval,
  output logic       cen,
  output logic       cen_dly,
  output logic       run,
  output logic       tif,
  output logic       trig_hit
);

  assign trig_hit = trig_evt && (smode == SM_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen     <= 1'b0;
      cen_dly <= 1'b0;
      tif     <= 1'b0;
    end else begin
      cen_dly <= cen;
      if (trig_hit)    cen <= 1'b1;
      else if (cen_we) cen <= cen_wval;
      if (trig_hit)    tif <= 1'b1;
      else if (tif_we) tif <= tif & tif_wval;
    end
  end

  // lockstep mode counts only once the enable has been seen for one cycle
  assign run = msm ? (cen & cen_dly) : cen;

  AST_TRIG_SETS_CEN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> cen); // R2
  AST_TRIG_SETS_TIF: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> tif); // R4
  AST_TIF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tif && !tif_we) |=> tif); // R4
  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (smode != SM_TRIG && !cen_we && !cen) |=> !cen); // R6

endmodule

// File: rtl/stt_count_core.sv
module stt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ug,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  input  logic         arr_we,
  input  logic [W-1:0] arr_val,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);

  localparam logic [W-1:0] ARR_RST = {W{1'b1}};

  logic [W-1:0] arr;

  function automatic logic [W-1:0] step_count(input logic [W-1:0] c,
                                               input logic [W-1:0] lim);
    return (c == lim) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt = run && (cnt == arr) && !ug && !ld_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      arr <= ARR_RST;
    end else begin
      if (arr_we) arr <= arr_val;
      if (ug)         cnt <= '0;
      else if (ld_we) cnt <= ld_val;
      else if (run)   cnt <= step_count(cnt, arr);
    end
  end

  AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0)); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ug && !ld_we && cnt != arr) |=> (cnt == W'($past(cnt) + 1'b1))); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && !ug) |=> (cnt == $past(ld_val))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug && !ld_we) |=> $stable(cnt)); // R13

endmodule

// File: rtl/stt_timer.sv
module stt_timer
  import stt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             itr_in,
  output logic             trg_out,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cen_o,
  output logic             tif_o
);

  mode_t mode_q;
  logic  mode_we, cen_we, cnt_we, arr_we, stat_we, ug_wr;
  logic  trig_evt, trig_hit, cen, cen_dly, run, tif, wrap_evt;
  logic  ug_q, wrap_q;

  assign mode_we = wr_en && (wr_addr == A_MODE);
  assign cen_we  = wr_en && (wr_addr == A_CTRL);
  assign cnt_we  = wr_en && (wr_addr == A_CNT);
  assign arr_we  = wr_en && (wr_addr == A_ARR);
  assign stat_we = wr_en && (wr_addr == A_STAT);
  assign ug_wr   = wr_en && (wr_addr == A_EVT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ug_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      ug_q   <= ug_wr;
      wrap_q <= wrap_evt;
    end
  end

  stt_trig_sel u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (ext_in),
    .itr_in   (itr_in),
    .tsel     (mode_q.tsel),
    .trig_evt (trig_evt)
  );

  stt_slave_ctrl u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_evt (trig_evt),
    .smode    (mode_q.smode),
    .msm      (mode_q.msm),
    .cen_we   (cen_we),
    .cen_wval (wr_data[0]),
    .tif_we   (stat_we),
    .tif_wval (wr_data[0]),
    .cen      (cen),
    .cen_dly  (cen_dly),
    .run      (run),
    .tif      (tif),
    .trig_hit (trig_hit)
  );

  stt_count_core #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ug       (ug_wr),
    .ld_we    (cnt_we),
    .ld_val   (wr_data),
    .arr_we   (arr_we),
    .arr_val  (wr_data),
    .cnt      (cnt_o),
    .wrap_evt (wrap_evt)
  );

  always_comb begin
    case (mode_q.msel)
      MM_ENABLE: trg_out = cen;
      MM_RESET:  trg_out = ug_q;
      MM_UPDATE: trg_out = wrap_q;
      default:   trg_out = 1'b0;
    endcase
  end

  assign cen_o = cen;
  assign tif_o = tif;

  AST_MSM_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.msm && cen && !cen_dly && !ug_wr && !cnt_we) |=> $stable(cnt_o)); // R11
  AST_RESET_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.msel == MM_RESET && !mode_we && trg_out && !ug_wr) |=> !trg_out); // R10
  AST_TRIG_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && cen_we && !wr_data[0]) |=> cen_o); // R13

endmodule

// File: tb/test_stt_timer.sv
module test_stt_timer;
  import stt_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ext_m = 1'b0, itr_m = 1'b0;
  logic we_m = 1'b0, we_s = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] data = '0;
  logic trg_m, trg_s, cen_m, cen_s, tif_m, tif_s;
  logic [W-1:0] cnt_m, cnt_s;
  int n_cmp = 0, n_bad = 0;

  stt_timer #(.CNT_W(W)) i_stt_timer (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_m), .itr_in(itr_m), .trg_out(trg_m),
    .wr_en(we_m), .wr_addr(addr), .wr_data(data),
    .cnt_o(cnt_m), .cen_o(cen_m), .tif_o(tif_m));

  stt_timer #(.CNT_W(W)) i_stt_timer_slv (
    .clk(clk), .rst_n(rst_n), .ext_in(1'b0), .itr_in(trg_m), .trg_out(trg_s),
    .wr_en(we_s), .wr_addr(addr), .wr_data(data),
    .cnt_o(cnt_s), .cen_o(cen_s), .tif_o(tif_s));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic m, input logic s, input logic [2:0] a, input logic [W-1:0] d);
    we_m = m; we_s = s; addr = a; data = d;
    @(negedge clk);
    we_m = 1'b0; we_s = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mode_word(input bit ms, input bit [2:0] msel,
                                             input bit [4:0] ts, input bit [2:0] sm);
    return W'({ms, msel, ts, sm});
  endfunction

  function automatic logic [W-1:0] nxt(input logic [W-1:0] c, input logic [W-1:0] lim);
    return W'((int'(c) + 1) % (int'(lim) + 1));
  endfunction

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 cnt", cnt_m, 0); check("R1 cen", cen_m, 0);
    check("R1 tif", tif_m, 0); check("R1 trg_out", trg_m, 0);

    // R7/R9 default limit and loads
    wr(1, 0, A_CNT, 16'hFFFE); check("R9 load", cnt_m, 16'hFFFE);
    wr(1, 0, A_CTRL, 1);       check("R13 enable set", cen_m, 1);
    check("R9 held before run", cnt_m, 16'hFFFE);
    tick(1); check("R7 step", cnt_m, 16'hFFFF);
    tick(1); check("R1 R7 wrap at all-ones limit", cnt_m, 0);
    wr(1, 0, A_CNT, 16'h0040); check("R9 write beats increment", cnt_m, 16'h40);
    tick(1); check("R7 step after load", cnt_m, 16'h41);
    wr(1, 0, A_CTRL, 0); check("R13 last step", cnt_m, 16'h42);
    check("R13 enable cleared", cen_m, 0);
    tick(2); check("R13 halted", cnt_m, 16'h42);

    // R8 forced reset
    wr(1, 0, A_EVT, 1); check("R8 idle clear", cnt_m, 0);
    wr(1, 0, A_CNT, 5); wr(1, 0, A_CTRL, 1); tick(2);
    check("R7 running", cnt_m, 7);
    wr(1, 0, A_EVT, 1); check("R8 clear beats increment", cnt_m, 0);
    tick(1); check("R8 resumes", cnt_m, 1);
    wr(1, 0, A_CTRL, 0);

    // R7 random limits and preloads
    for (int it = 0; it < 8; it++) begin
      logic [W-1:0] a, e;
      int k;
      a = W'($urandom_range(20, 1));
      e = W'($urandom_range(int'(a), 0));
      wr(1, 0, A_ARR, a); wr(1, 0, A_CNT, e); wr(1, 0, A_CTRL, 1);
      check("R7 start value", cnt_m, e);
      k = $urandom_range(40, 5);
      for (int c = 0; c < k; c++) begin
        tick(1); e = nxt(e, a); check("R7 run", cnt_m, e);
      end
      wr(1, 0, A_CTRL, 0); e = nxt(e, a); check("R13 stop", cnt_m, e);
    end

    // R2 external edge trigger, R10 enable export
    wr(1, 0, A_ARR, 100); wr(1, 0, A_EVT, 1);
    wr(1, 0, A_MODE, mode_word(0, MM_ENABLE, TS_ETI1, SM_TRIG));
    ext_m = 1'b1; tick(1);
    check("R2 enable set", cen_m, 1); check("R4 flag set", tif_m, 1);
    check("R10 trg follows enable", trg_m, 1); check("R2 count not yet", cnt_m, 0);
    tick(1); check("R2 first step", cnt_m, 1);
    wr(1, 0, A_CTRL, 0); check("R10 trg drops", trg_m, 0); check("R13 stop", cnt_m, 2);
    wr(1, 0, A_STAT, 0); check("R4 clear by 0", tif_m, 0);
    tick(3); check("R2 level no retrigger", cen_m, 0); check("R2 flag stays 0", tif_m, 0);
    ext_m = 1'b0; tick(1); ext_m = 1'b1; tick(1);
    check("R2 retrigger", cen_m, 1); check("R4 flag again", tif_m, 1);
    wr(1, 0, A_STAT, 1); check("R4 write 1 no effect", tif_m, 1); check("R7 cnt", cnt_m, 3);
    // R5 trigger while running
    ext_m = 1'b0; tick(1); ext_m = 1'b1; tick(1);
    check("R5 no counter reset", cnt_m, 5); check("R5 enable still", cen_m, 1);
    // R4 collision: trigger with clearing write
    ext_m = 1'b0; wr(1, 0, A_STAT, 0); check("R4 cleared", tif_m, 0);
    ext_m = 1'b1; wr(1, 0, A_STAT, 0); check("R4 trigger beats clear", tif_m, 1);
    // R13 collision: trigger with enable clear
    ext_m = 1'b0; tick(1);
    ext_m = 1'b1; wr(1, 0, A_CTRL, 0); check("R13 trigger beats clear", cen_m, 1);
    check("R5 count continues", cnt_m, 9);
    ext_m = 1'b0; wr(1, 0, A_CTRL, 0); wr(1, 0, A_STAT, 0);

    // R6 ignored triggers
    wr(1, 0, A_MODE, mode_word(0, MM_ENABLE, TS_ETI1, SM_OFF));
    ext_m = 1'b1; tick(1);
    check("R6 slave off enable", cen_m, 0); check("R6 slave off flag", tif_m, 0);
    ext_m = 1'b0;
    wr(1, 0, A_MODE, mode_word(0, MM_ENABLE, 5'b00001, SM_TRIG));
    ext_m = 1'b1; itr_m = 1'b1; tick(1);
    check("R6 bad select enable", cen_m, 0); check("R6 bad select flag", tif_m, 0);
    ext_m = 1'b0; itr_m = 1'b0; tick(1);

    // R3 internal trigger
    wr(1, 0, A_MODE, mode_word(0, MM_ENABLE, TS_ITR0, SM_TRIG));
    ext_m = 1'b1; tick(1); check("R6 ext ignored under itr select", cen_m, 0);
    itr_m = 1'b1; tick(1);
    check("R3 enable set", cen_m, 1); check("R3 flag set", tif_m, 1);
    ext_m = 1'b0; itr_m = 1'b0;
    wr(1, 0, A_CTRL, 0); wr(1, 0, A_STAT, 0);

    // R10 reset and update pulses
    wr(1, 0, A_MODE, mode_word(0, MM_RESET, TS_ITR0, SM_OFF));
    check("R10 reset mode idle", trg_m, 0);
    wr(1, 0, A_EVT, 1); check("R10 reset pulse", trg_m, 1); check("R8 cnt", cnt_m, 0);
    tick(1); check("R10 reset pulse ends", trg_m, 0);
    wr(1, 0, A_MODE, mode_word(0, MM_UPDATE, TS_ITR0, SM_OFF));
    wr(1, 0, A_ARR, 3); wr(1, 0, A_CNT, 1); wr(1, 0, A_CTRL, 1);
    tick(1); check("R10 no pulse mid", trg_m, 0);
    tick(1); check("R7 at limit", cnt_m, 3); check("R10 no pulse at limit", trg_m, 0);
    tick(1); check("R7 wrapped", cnt_m, 0); check("R10 wrap pulse", trg_m, 1);
    tick(1); check("R10 wrap pulse ends", trg_m, 0);
    wr(1, 0, A_CTRL, 0);

    // R11 lockstep delay alone
    wr(1, 0, A_ARR, 100); wr(1, 0, A_EVT, 1);
    wr(1, 0, A_MODE, mode_word(1, MM_ENABLE, TS_ETI1, SM_TRIG));
    ext_m = 1'b1; tick(1); check("R11 enable set", cen_m, 1); check("R11 cnt", cnt_m, 0);
    tick(1); check("R11 held one extra cycle", cnt_m, 0);
    tick(1); check("R11 first step", cnt_m, 1);
    ext_m = 1'b0; wr(1, 0, A_CTRL, 0); check("R11 stop", cnt_m, 2);
    tick(1); check("R13 held", cnt_m, 2);

    // R12 chained pair
    wr(0, 1, A_MODE, mode_word(0, MM_RESET, TS_ITR0, SM_TRIG));
    for (int it = 0; it < 4; it++) begin
      logic [W-1:0] a, em, es;
      int k;
      a = W'($urandom_range(30, 5));
      es = W'($urandom_range(int'(a), 0));
      wr(1, 1, A_ARR, a); wr(1, 1, A_EVT, 1); wr(0, 1, A_CNT, es); wr(1, 1, A_STAT, 0);
      ext_m = 1'b1; tick(1);
      check("R12 master enabled", cen_m, 1); check("R12 slave not yet", cen_s, 0);
      tick(1);
      check("R12 slave enabled", cen_s, 1); check("R12 slave flag", tif_s, 1);
      check("R12 master start", cnt_m, 0); check("R12 slave start", cnt_s, es);
      em = '0;
      k = $urandom_range(50, 10);
      for (int c = 0; c < k; c++) begin
        tick(1); em = nxt(em, a); es = nxt(es, a);
        check("R12 master", cnt_m, em); check("R12 slave", cnt_s, es);
      end
      ext_m = 1'b0; wr(1, 1, A_CTRL, 0);
      em = nxt(em, a); es = nxt(es, a);
      check("R12 master stop", cnt_m, em); check("R12 slave stop", cnt_s, es);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule